// File: doc/BRIEF.md
# Compact Branch Resolution Unit

This purely combinational unit sits beside the register read stage of a RISC core. It resolves branches and jumps that have no delay slot in the same evaluation in which it sees them. It takes the 32-bit instruction word, the address of that instruction and the values read for the two source register fields. From these it produces the branch decision, the destination address, a return-address write with its value, and a flag telling the issue logic that the next instruction may not be a control transfer.

Several major opcodes carry more than one branch kind. The kind is chosen by comparing the two register-number fields with each other and with zero, and not only by the register contents. The unit therefore decodes those numbers itself and then evaluates the matching condition on the operand values. Encodings that reserve a zero register number in the linking groups are reported as illegal, and nothing else happens for them. Every opcode the unit does not own leaves all of its outputs low.

Top module: `cbr_resolve`

## Requirements
- R1: Opcode bits [31:26] = 110010 is an unconditional branch and 111010 is the same with a link. The target is PC+4 plus instruction bits [25:0] sign-extended and multiplied by 4, and the branch is always taken.
- R2: For opcodes 110110 and 111110 with field A (bits [25:21]) nonzero, the branch is taken when the field-A operand is zero (110110) or nonzero (111110). The target is PC+4 plus bits [20:0] sign-extended times 4.
- R3: For opcodes 110110 and 111110 with field A zero, an unconditional jump goes to the field-B operand plus bits [15:0] sign-extended, with no scaling. Only 111110 links.
- R4: Opcode 010110 takes one of three forms. With A=0 and B≠0 it branches if operand B <= 0. With A≠0 and A=B it branches if operand B >= 0. For any other pair it branches if A >= B as signed values. Every 16-bit-offset branch targets PC+4 plus bits [15:0] sign-extended times 4.
- R5: Opcode 010111 uses the same field decode as R4, with the conditions B > 0, B < 0 and signed A < B.
- R6: Opcodes 000110 and 000111 use the R4 and R5 decode. Their zero-compare forms link whether taken or not. Their two-register forms compare without sign and do not link.
- R7: For opcode 001000, A >= B as register numbers selects a branch on signed overflow of the 32-bit sum of the low operand words. Otherwise A=0 selects branch-and-link if operand B is zero, and any remaining pair selects branch if the operands are equal.
- R8: Opcode 011000 mirrors R7: branch on no overflow, branch-and-link if operand B is nonzero, and branch if the operands are not equal.
- R9: The forbidden-slot flag is high exactly when a legal conditional branch is not taken. It is never high for a taken branch or for the unconditional forms.
- R10: Opcodes 000110 and 000111 with field B zero raise the illegal flag and keep the taken, link and forbidden-slot outputs low.
- R11: The target and link value are computed modulo 2^XLEN and wrap without any other effect. A link writes PC+4.
- R12: Any other opcode leaves the taken, link, forbidden-slot and illegal outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under evaluation |
| pc_i | input | XLEN | Address of the instruction |
| src_a_i | input | XLEN | Value of the register named by bits [25:21] |
| src_b_i | input | XLEN | Value of the register named by bits [20:16] |
| take_o | output | 1 | Control transfer is taken |
| target_o | output | XLEN | Destination address |
| link_we_o | output | 1 | Write the return address |
| link_val_o | output | XLEN | Return address (PC+4) |
| fslot_o | output | 1 | Next instruction must not transfer control |
| illegal_o | output | 1 | Reserved encoding detected |

## Verification
The hardest case to reach is the one where the register numbers alone change the meaning of an opcode. An example is a field pair where A equals B, which turns a two-operand compare into a zero test on B. Another is a pair with A above B, which turns an equality branch into an overflow branch. The stimulus encodes each field relation on purpose: A=0, A=B, A>B and A<B. It gives the operands values, such as -1 against 1 or 0x7FFFFFFF plus 1, on which the signed reading, the unsigned reading and the overflow reading give different answers. A mis-decoded form therefore shows up as a wrong taken or forbidden-slot result.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;
   localparam int REG_W  = 5;

   localparam logic [OPC_W-1:0] OPC_JMP26    = 6'b110010;
   localparam logic [OPC_W-1:0] OPC_JMP26_LK = 6'b111010;
   localparam logic [OPC_W-1:0] OPC_ZEQ_JR   = 6'b110110;
   localparam logic [OPC_W-1:0] OPC_ZNE_JRL  = 6'b111110;
   localparam logic [OPC_W-1:0] OPC_GE_GRP   = 6'b010110;
   localparam logic [OPC_W-1:0] OPC_LT_GRP   = 6'b010111;
   localparam logic [OPC_W-1:0] OPC_GEL_GRP  = 6'b000110;
   localparam logic [OPC_W-1:0] OPC_LTL_GRP  = 6'b000111;
   localparam logic [OPC_W-1:0] OPC_EQ_GRP   = 6'b001000;
   localparam logic [OPC_W-1:0] OPC_NE_GRP   = 6'b011000;

   typedef enum logic [4:0] {
      C_ALWAYS, C_A_EQZ, C_A_NEZ, C_B_LEZ, C_B_GEZ, C_B_GTZ, C_B_LTZ,
      C_B_EQZ, C_B_NEZ, C_GE_S, C_LT_S, C_GE_U, C_LT_U, C_EQ, C_NE,
      C_OVF, C_NOVF
   } cond_e;

   typedef enum logic [1:0] { OFF_26, OFF_21, OFF_16, OFF_REG } off_e;

   typedef struct packed {
      logic  valid;
      logic  illegal;
      logic  link;
      cond_e cond;
      off_e  off;
   } ctl_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
   import cbr_pkg::*;
(
   input  logic [INSN_W-1:0] instr_i,
   output ctl_t              ctl_o
);
   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] fa, fb;
   logic a_zero, b_zero, same, a_ge_b;

   assign opc    = instr_i[31:26];
   assign fa     = instr_i[25:21];
   assign fb     = instr_i[20:16];
   assign a_zero = (fa == '0);
   assign b_zero = (fb == '0);
   assign same   = (fa == fb);
   assign a_ge_b = (fa >= fb);

   always_comb begin
      ctl_o         = '0;
      ctl_o.cond    = C_ALWAYS;
      ctl_o.off     = OFF_16;
      case (opc)
         OPC_JMP26, OPC_JMP26_LK: begin
            ctl_o.valid = 1'b1;
            ctl_o.link  = (opc == OPC_JMP26_LK);
            ctl_o.off   = OFF_26;
         end
         OPC_ZEQ_JR, OPC_ZNE_JRL: begin
            ctl_o.valid = 1'b1;
            if (a_zero) begin
               ctl_o.off  = OFF_REG;
               ctl_o.link = (opc == OPC_ZNE_JRL);
            end else begin
               ctl_o.off  = OFF_21;
               ctl_o.cond = (opc == OPC_ZEQ_JR) ? C_A_EQZ : C_A_NEZ;
            end
         end
         OPC_GE_GRP: begin
            ctl_o.valid = 1'b1;
            if (a_zero && !b_zero) ctl_o.cond = C_B_LEZ;
            else if (!a_zero && same) ctl_o.cond = C_B_GEZ;
            else ctl_o.cond = C_GE_S;
         end
         OPC_LT_GRP: begin
            ctl_o.valid = 1'b1;
            if (a_zero && !b_zero) ctl_o.cond = C_B_GTZ;
            else if (!a_zero && same) ctl_o.cond = C_B_LTZ;
            else ctl_o.cond = C_LT_S;
         end
         OPC_GEL_GRP, OPC_LTL_GRP: begin
            ctl_o.valid = 1'b1;
            if (b_zero) begin
               ctl_o.illegal = 1'b1;
            end else if (a_zero) begin
               ctl_o.link = 1'b1;
               ctl_o.cond = (opc == OPC_GEL_GRP) ? C_B_LEZ : C_B_GTZ;
            end else if (same) begin
               ctl_o.link = 1'b1;
               ctl_o.cond = (opc == OPC_GEL_GRP) ? C_B_GEZ : C_B_LTZ;
            end else begin
               ctl_o.cond = (opc == OPC_GEL_GRP) ? C_GE_U : C_LT_U;
            end
         end
         OPC_EQ_GRP, OPC_NE_GRP: begin
            ctl_o.valid = 1'b1;
            if (a_ge_b) begin
               ctl_o.cond = (opc == OPC_EQ_GRP) ? C_OVF : C_NOVF;
            end else if (a_zero) begin
               ctl_o.link = 1'b1;
               ctl_o.cond = (opc == OPC_EQ_GRP) ? C_B_EQZ : C_B_NEZ;
            end else begin
               ctl_o.cond = (opc == OPC_EQ_GRP) ? C_EQ : C_NE;
            end
         end
         default: ctl_o = ctl_o;
      endcase
   end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
   import cbr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit OVF_CARRY = 1'b1
) (
   input  cond_e           cond_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            hit_o
);
   localparam int WORD = 32;

   logic ovf;

   generate
      if (OVF_CARRY) begin : g_ovf_carry
         logic [WORD-1:0] low_sum;
         logic [WORD:0]   full_sum;
         assign low_sum  = {1'b0, a_i[WORD-2:0]} + {1'b0, b_i[WORD-2:0]};
         assign full_sum = {1'b0, a_i[WORD-1:0]} + {1'b0, b_i[WORD-1:0]};
         assign ovf      = low_sum[WORD-1] ^ full_sum[WORD];
      end else begin : g_ovf_sign
         logic [WORD-1:0] sum;
         assign sum = a_i[WORD-1:0] + b_i[WORD-1:0];
         assign ovf = (a_i[WORD-1] == b_i[WORD-1]) && (sum[WORD-1] != a_i[WORD-1]);
      end
   endgenerate

   logic a_z, b_z, b_neg;
   assign a_z   = (a_i == '0);
   assign b_z   = (b_i == '0);
   assign b_neg = b_i[XLEN-1];

   always_comb begin
      unique case (cond_i)
         C_ALWAYS: hit_o = 1'b1;
         C_A_EQZ:  hit_o = a_z;
         C_A_NEZ:  hit_o = !a_z;
         C_B_LEZ:  hit_o = b_neg || b_z;
         C_B_GEZ:  hit_o = !b_neg;
         C_B_GTZ:  hit_o = !b_neg && !b_z;
         C_B_LTZ:  hit_o = b_neg;
         C_B_EQZ:  hit_o = b_z;
         C_B_NEZ:  hit_o = !b_z;
         C_GE_S:   hit_o = $signed(a_i) >= $signed(b_i);
         C_LT_S:   hit_o = $signed(a_i) <  $signed(b_i);
         C_GE_U:   hit_o = a_i >= b_i;
         C_LT_U:   hit_o = a_i <  b_i;
         C_EQ:     hit_o = (a_i == b_i);
         C_NE:     hit_o = (a_i != b_i);
         C_OVF:    hit_o = ovf;
         C_NOVF:   hit_o = !ovf;
         default:  hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
   import cbr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  off_e            off_i,
   input  logic [25:0]     imm_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] base_i,
   output logic [XLEN-1:0] target_o,
   output logic [XLEN-1:0] next_pc_o
);
   localparam int STEP = 4;

   logic [XLEN-1:0] ofs26, ofs21, ofs16, ofsreg, ofs, base;

   assign next_pc_o = pc_i + XLEN'(STEP);
   assign ofs26  = {{(XLEN-28){imm_i[25]}}, imm_i[25:0], 2'b00};
   assign ofs21  = {{(XLEN-23){imm_i[20]}}, imm_i[20:0], 2'b00};
   assign ofs16  = {{(XLEN-18){imm_i[15]}}, imm_i[15:0], 2'b00};
   assign ofsreg = {{(XLEN-16){imm_i[15]}}, imm_i[15:0]};

   always_comb begin
      base = next_pc_o;
      unique case (off_i)
         OFF_26:  ofs = ofs26;
         OFF_21:  ofs = ofs21;
         OFF_16:  ofs = ofs16;
         OFF_REG: begin
            ofs  = ofsreg;
            base = base_i;
         end
         default: ofs = ofs16;
      endcase
   end

   assign target_o = base + ofs;
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
   import cbr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit OVF_CARRY = 1'b1
) (
   input  logic [INSN_W-1:0] instr_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   src_a_i,
   input  logic [XLEN-1:0]   src_b_i,
   output logic              take_o,
   output logic [XLEN-1:0]   target_o,
   output logic              link_we_o,
   output logic [XLEN-1:0]   link_val_o,
   output logic              fslot_o,
   output logic              illegal_o
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("cbr_resolve: XLEN must be at least 32");
      end
   endgenerate

   ctl_t ctl;
   logic hit, legal, cond_br;

   cbr_decode u_dec (.instr_i(instr_i), .ctl_o(ctl));

   cbr_cond #(.XLEN(XLEN), .OVF_CARRY(OVF_CARRY)) u_cond (
      .cond_i(ctl.cond), .a_i(src_a_i), .b_i(src_b_i), .hit_o(hit));

   cbr_target #(.XLEN(XLEN)) u_tgt (
      .off_i(ctl.off), .imm_i(instr_i[25:0]), .pc_i(pc_i), .base_i(src_b_i),
      .target_o(target_o), .next_pc_o(link_val_o));

   assign legal     = ctl.valid && !ctl.illegal;
   assign cond_br   = (ctl.cond != C_ALWAYS);
   assign take_o    = legal && hit;
   assign link_we_o = legal && ctl.link;
   assign fslot_o   = legal && cond_br && !hit;
   assign illegal_o = ctl.valid && ctl.illegal;

   logic known;
   assign known = !$isunknown({instr_i, pc_i, src_a_i, src_b_i});

   always_comb begin
      if (known) begin
         AST_RSVD_QUIET: assert (!illegal_o || !(take_o || link_we_o || fslot_o)); // R10
         AST_SLOT_EXCL: assert (!(take_o && fslot_o)); // R9
         AST_UNCOND_TAKEN: assert (instr_i[31:26] != OPC_JMP26 || (take_o && !fslot_o)); // R1
         AST_WORD_ALIGN: assert (!(take_o && pc_i[1:0] == 2'b00
                                   && instr_i[31:26] != OPC_ZEQ_JR
                                   && instr_i[31:26] != OPC_ZNE_JRL)
                                 || target_o[1:0] == 2'b00); // R11
         AST_FOREIGN_QUIET: assert (ctl.valid || !(take_o || link_we_o || fslot_o || illegal_o)); // R12
      end
   end
endmodule

// File: tb/test_cbr_resolve.sv
`timescale 1ns/1ps
module test_cbr_resolve;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [31:0] instr, pc, sa, sb;
   logic        take, lwe, fs, ill;
   logic [31:0] tgt, lval;

   cbr_resolve #(.XLEN(32)) i_cbr_resolve (
      .instr_i(instr), .pc_i(pc), .src_a_i(sa), .src_b_i(sb),
      .take_o(take), .target_o(tgt), .link_we_o(lwe), .link_val_o(lval),
      .fslot_o(fs), .illegal_o(ill));

   typedef struct {
      logic        tk;
      logic [31:0] tg;
      logic        lw;
      logic [31:0] lv;
      logic        fs;
      logic        il;
      string       tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] e16(input logic [5:0] o, input logic [4:0] a, input logic [4:0] b,
                                       input logic [15:0] off);
      return {o, a, b, off};
   endfunction
   function automatic logic [31:0] e21(input logic [5:0] o, input logic [4:0] a, input logic [20:0] off);
      return {o, a, off};
   endfunction
   function automatic logic [31:0] e26(input logic [5:0] o, input logic [25:0] off);
      return {o, off};
   endfunction

   task automatic send(input logic [31:0] ins, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic tk, input logic [31:0] tg,
                       input logic lw, input logic [31:0] lv, input logic f, input logic il,
                       input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      instr = ins; pc = p; sa = a; sb = b;
      e.tk = tk; e.tg = tg; e.lw = lw; e.lv = lv; e.fs = f; e.il = il; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compare on the falling edge, one item per cycle
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         bit bad;
         e = q.pop_front();
         bad = (take !== e.tk) || (lwe !== e.lw) || (fs !== e.fs) || (ill !== e.il)
               || (e.tk && tgt !== e.tg) || (e.lw && lval !== e.lv);
         n_chk++;
         if (bad) begin
            n_fail++;
            $display("FAIL %s: got take=%0b tgt=%h link=%0b lval=%h fslot=%0b ill=%0b ; exp take=%0b tgt=%h link=%0b lval=%h fslot=%0b ill=%0b",
                     e.tag, take, tgt, lwe, lval, fs, ill, e.tk, e.tg, e.lw, e.lv, e.fs, e.il);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   localparam logic [31:0] P  = 32'h0000_1000;
   localparam logic [31:0] N4 = 32'h0000_1004;

   initial begin
      instr = '0; pc = P; sa = '0; sb = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle / reset-state: opcode 000000
      send(32'h0000_0000, P, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle zero word");
      // R1
      send(e26(6'b110010, 26'h10), P, 0, 0, 1, 32'h1044, 0, 0, 0, 0, "R1 fwd");
      send(e26(6'b110010, 26'h3FFFFFF), P, 0, 0, 1, 32'h1000, 0, 0, 0, 0, "R1 back");
      send(e26(6'b111010, 26'h100), P, 0, 0, 1, 32'h1404, 1, N4, 0, 0, "R1 link");
      // R2
      send(e21(6'b110110, 5'd5, 21'h10), P, 0, 7, 1, 32'h1044, 0, 0, 0, 0, "R2 eqz taken");
      send(e21(6'b110110, 5'd5, 21'h10), P, 7, 0, 0, 0, 0, 0, 1, 0, "R2 eqz not taken");
      send(e21(6'b111110, 5'd3, 21'h1FFFF8), P, 1, 0, 1, 32'h0FE4, 0, 0, 0, 0, "R2 nez back");
      // R3
      send(e16(6'b110110, 5'd0, 5'd9, 16'hFFFC), P, 0, 32'h2000, 1, 32'h1FFC, 0, 0, 0, 0, "R3 reg jump");
      send(e16(6'b111110, 5'd0, 5'd9, 16'h0010), P, 0, 32'h3000, 1, 32'h3010, 1, N4, 0, 0, "R3 reg jump link");
      // R4
      send(e16(6'b010110, 5'd0, 5'd4, 16'h0008), P, 9, 0, 1, 32'h1024, 0, 0, 0, 0, "R4 lez zero");
      send(e16(6'b010110, 5'd0, 5'd4, 16'h0008), P, 9, 1, 0, 0, 0, 0, 1, 0, "R4 lez pos");
      send(e16(6'b010110, 5'd6, 5'd6, 16'h0008), P, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 1, 0, "R4 gez neg");
      send(e16(6'b010110, 5'd6, 5'd6, 16'h0008), P, 5, 5, 1, 32'h1024, 0, 0, 0, 0, "R4 gez pos");
      send(e16(6'b010110, 5'd2, 5'd3, 16'h0008), P, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, 0, "R4 signed ge");
      // R5
      send(e16(6'b010111, 5'd0, 5'd4, 16'h0001), P, 0, 0, 0, 0, 0, 0, 1, 0, "R5 gtz zero");
      send(e16(6'b010111, 5'd6, 5'd6, 16'h0001), P, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 1, 32'h1008, 0, 0, 0, 0, "R5 ltz");
      send(e16(6'b010111, 5'd2, 5'd3, 16'h0001), P, 32'hFFFF_FFFF, 1, 1, 32'h1008, 0, 0, 0, 0, "R5 signed lt");
      // R6
      send(e16(6'b000110, 5'd0, 5'd4, 16'h0002), P, 0, 5, 0, 0, 1, N4, 1, 0, "R6 lez link not taken");
      send(e16(6'b000110, 5'd2, 5'd3, 16'h0002), P, 32'hFFFF_FFFF, 1, 1, 32'h100C, 0, 0, 0, 0, "R6 unsigned ge");
      send(e16(6'b000111, 5'd7, 5'd7, 16'h0002), P, 32'h8000_0000, 32'h8000_0000, 1, 32'h100C, 1, N4, 0, 0, "R6 ltz link");
      send(e16(6'b000111, 5'd2, 5'd3, 16'h0002), P, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 1, 0, "R6 unsigned lt");
      // R10
      send(e16(6'b000110, 5'd5, 5'd0, 16'h0002), P, 0, 0, 0, 0, 0, 0, 0, 1, "R10 rsvd ge grp");
      send(e16(6'b000111, 5'd0, 5'd0, 16'h0002), P, 0, 0, 0, 0, 0, 0, 0, 1, "R10 rsvd lt grp");
      // R7
      send(e16(6'b001000, 5'd5, 5'd3, 16'h0004), P, 32'h7FFF_FFFF, 1, 1, 32'h1014, 0, 0, 0, 0, "R7 ovf taken");
      send(e16(6'b001000, 5'd3, 5'd3, 16'h0004), P, 1, 1, 0, 0, 0, 0, 1, 0, "R7 ovf none");
      send(e16(6'b001000, 5'd0, 5'd4, 16'h0004), P, 3, 0, 1, 32'h1014, 1, N4, 0, 0, "R7 eqz link");
      send(e16(6'b001000, 5'd2, 5'd3, 16'h0004), P, 32'h55, 32'h55, 1, 32'h1014, 0, 0, 0, 0, "R7 eq");
      // R8
      send(e16(6'b011000, 5'd5, 5'd3, 16'h0004), P, 32'h7FFF_FFFF, 1, 0, 0, 0, 0, 1, 0, "R8 nov pos ovf");
      send(e16(6'b011000, 5'd5, 5'd3, 16'h0004), P, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 0, "R8 nov neg ovf");
      send(e16(6'b011000, 5'd5, 5'd3, 16'h0004), P, 1, 2, 1, 32'h1014, 0, 0, 0, 0, "R8 nov taken");
      send(e16(6'b011000, 5'd0, 5'd4, 16'h0004), P, 3, 0, 0, 0, 1, N4, 1, 0, "R8 nez link not taken");
      send(e16(6'b011000, 5'd2, 5'd3, 16'h0004), P, 32'h55, 32'h56, 1, 32'h1014, 0, 0, 0, 0, "R8 ne");
      // R11 wrap
      send(e26(6'b110010, 26'h10), 32'hFFFF_FFF0, 0, 0, 1, 32'h0000_0034, 0, 0, 0, 0, "R11 target wrap");
      send(e26(6'b111010, 26'h0), 32'hFFFF_FFFC, 0, 0, 1, 32'h0, 1, 32'h0, 0, 0, "R11 link wrap");
      // R12
      send(e16(6'b001111, 5'd0, 5'd4, 16'h1234), P, 0, 0, 0, 0, 0, 0, 0, 0, "R12 foreign opcode");
      send(e16(6'b000000, 5'd3, 5'd0, 16'hFFFF), P, 0, 0, 0, 0, 0, 0, 0, 0, "R12 special opcode");
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule